// File: doc/BRIEF.md
# Multi-input edge wakeup controller

This block watches eight asynchronous input pins and records a chosen transition on each one. Every pin has three bits of its own. A polarity bit selects whether the pin reacts to a rising or a falling transition. An enable bit decides whether the pin may take part in a request. A pending bit records that the selected transition happened. The block drives a level wakeup/interrupt request while any pin is both enabled and pending. It also tells the core whether a HALT attempt may go ahead.

Software reaches the three registers through a small register port. The port can write a whole byte, or set or clear a single bit picked by a 3-bit index. Each pin passes through a two-flop synchroniser. Transitions are detected on the synchronised pin after it is XORed with its polarity bit. Because of this, flipping a polarity bit while the pin is static can itself record an event. The safe way to change a polarity bit is: disable the pin, change the polarity, clear its pending bit, then enable it again.

Top module: `wake_edge_ctrl`

## Requirements
- R1: A pin with polarity bit 0 sets its pending bit on a low-to-high transition. A pin with polarity bit 1 sets its pending bit on a high-to-low transition. The opposite transition leaves the pending bit unchanged, and no other pin's pending bit changes.
- R2: A pending bit, once set, stays set until software clears it. A pending bit latches events whether its enable bit is 0 or 1.
- R3: Reset clears the polarity and enable registers to 0x00. The pending register is not reset.
- R4: `wake_req_o` is high exactly when the bitwise AND of the enable and pending registers is nonzero. It is a level signal.
- R5: `halt_ok_o` equals `halt_req_i` AND NOT `wake_req_o`.
- R6: Register access is as follows.
  - `bus_op_i` encodings: 0 idle, 1 byte write of `bus_wdata_i`, 2 set bit `bus_idx_i`, 3 clear bit `bus_idx_i`.
  - `bus_sel_i` encodings: 0 polarity, 1 enable, 2 pending, 3 no register.
  - An operation takes effect at the next rising clock edge.
  - `rd_data_o` shows the selected register combinationally, and reads 0x00 when `bus_sel_i` is 3.
- R7: If a software write or clear of a pending bit and a new hardware event for that bit take effect at the same clock edge, the bit ends up set.
- R8: Changing a polarity bit from 0 to 1 while its pin is low sets that pin's pending bit. Changing it from 1 to 0 while the pin is low sets nothing.
- R9: A pin change made between two clock edges is visible in the pending register after the third following rising edge. It is not visible after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pin_i | input | 8 | Asynchronous wakeup pins |
| bus_op_i | input | 2 | Register operation (R6 encoding) |
| bus_sel_i | input | 2 | Register select (R6 encoding) |
| bus_idx_i | input | 3 | Bit index for set/clear |
| bus_wdata_i | input | 8 | Byte write data |
| rd_data_o | output | 8 | Selected register contents |
| halt_req_i | input | 1 | Core asks to enter HALT |
| wake_req_o | output | 1 | Wakeup/interrupt request |
| halt_ok_o | output | 1 | HALT entry permitted |

## Verification
The hardest case to reach is a pending-bit clear that lands on the same clock edge as a fresh hardware event.

The event reaches the register only after the two synchroniser flops and the edge detector. The stimulus therefore changes the pin on a falling edge and waits exactly two rising edges. It then issues the clear, so that the clear and the detected event are applied at the same edge.

The polarity-driven false trigger is reached by writing the polarity register while every pin is held low.

// File: rtl/wake_pkg.sv
package wake_pkg;
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_WRITE = 2'd1,
        OP_SET   = 2'd2,
        OP_CLR   = 2'd3
    } bus_op_e;

    typedef enum logic [1:0] {
        SEL_POL  = 2'd0,
        SEL_EN   = 2'd1,
        SEL_PEND = 2'd2,
        SEL_NONE = 2'd3
    } bus_sel_e;
endpackage

// File: rtl/wake_sync.sv
module wake_sync #(
    parameter int N_PINS = 8,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PINS-1:0] pin_i,
    output logic [N_PINS-1:0] sync_o
);
    logic [N_PINS-1:0] stg_d [STAGES];
    logic [N_PINS-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = pin_i;
        for (int s = 1; s < STAGES; s++) begin
            stg_d[s] = stg_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                stg_q[s] <= '0;
            end
        end else begin
            for (int s = 0; s < STAGES; s++) begin
                stg_q[s] <= stg_d[s];
            end
        end
    end

    assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/wake_edge_det.sv
module wake_edge_det #(
    parameter int N_PINS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PINS-1:0] sync_i,
    input  logic [N_PINS-1:0] pol_i,
    output logic [N_PINS-1:0] evt_o
);
    logic [N_PINS-1:0] lvl;
    logic [N_PINS-1:0] lvl_prev_d;
    logic [N_PINS-1:0] lvl_prev_q;

    always_comb begin
        lvl        = sync_i ^ pol_i;
        lvl_prev_d = lvl;
        evt_o      = lvl & ~lvl_prev_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_prev_q <= '0;
        else        lvl_prev_q <= lvl_prev_d;
    end
endmodule

// File: rtl/wake_regs.sv
module wake_regs
    import wake_pkg::*;
#(
    parameter int N_PINS = 8,
    localparam int IDX_W = $clog2(N_PINS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bus_op_e           op_i,
    input  bus_sel_e          sel_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [N_PINS-1:0] wdata_i,
    input  logic [N_PINS-1:0] evt_i,
    output logic [N_PINS-1:0] pol_o,
    output logic [N_PINS-1:0] en_o,
    output logic [N_PINS-1:0] pend_o
);
    typedef struct packed {
        logic [N_PINS-1:0] pol;
        logic [N_PINS-1:0] en;
        logic [N_PINS-1:0] pend;
    } regs_t;

    regs_t             r_d, r_q;
    logic [N_PINS-1:0] bit_mask;

    function automatic logic [N_PINS-1:0] apply_op(
        input bus_op_e           op,
        input logic [N_PINS-1:0] cur,
        input logic [N_PINS-1:0] data,
        input logic [N_PINS-1:0] mask
    );
        case (op)
            OP_WRITE: apply_op = data;
            OP_SET:   apply_op = cur | mask;
            OP_CLR:   apply_op = cur & ~mask;
            default:  apply_op = cur;
        endcase
    endfunction

    always_comb begin
        bit_mask = {{(N_PINS-1){1'b0}}, 1'b1} << idx_i;
        r_d      = r_q;
        case (sel_i)
            SEL_POL:  r_d.pol  = apply_op(op_i, r_q.pol,  wdata_i, bit_mask);
            SEL_EN:   r_d.en   = apply_op(op_i, r_q.en,   wdata_i, bit_mask);
            SEL_PEND: r_d.pend = apply_op(op_i, r_q.pend, wdata_i, bit_mask);
            default:  ;
        endcase
        // hardware event overrides any software clear in the same cycle
        r_d.pend = r_d.pend | evt_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.pol <= '0;
            r_q.en  <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign pol_o  = r_q.pol;
    assign en_o   = r_q.en;
    assign pend_o = r_q.pend;
endmodule

// File: rtl/wake_edge_ctrl.sv
module wake_edge_ctrl
    import wake_pkg::*;
#(
    parameter int N_PINS      = 8,
    parameter int SYNC_STAGES = 2,
    localparam int IDX_W      = $clog2(N_PINS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PINS-1:0] pin_i,
    input  logic [1:0]        bus_op_i,
    input  logic [1:0]        bus_sel_i,
    input  logic [IDX_W-1:0]  bus_idx_i,
    input  logic [N_PINS-1:0] bus_wdata_i,
    output logic [N_PINS-1:0] rd_data_o,
    input  logic              halt_req_i,
    output logic              wake_req_o,
    output logic              halt_ok_o
);
    logic [N_PINS-1:0] pin_sync;
    logic [N_PINS-1:0] pin_evt;
    logic [N_PINS-1:0] pol_q;
    logic [N_PINS-1:0] en_q;
    logic [N_PINS-1:0] pend_q;
    bus_op_e           op;
    bus_sel_e          sel;

    assign op  = bus_op_e'(bus_op_i);
    assign sel = bus_sel_e'(bus_sel_i);

    wake_sync #(.N_PINS(N_PINS), .STAGES(SYNC_STAGES)) i_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (pin_i),
        .sync_o (pin_sync)
    );

    wake_edge_det #(.N_PINS(N_PINS)) i_det (
        .clk    (clk),
        .rst_n  (rst_n),
        .sync_i (pin_sync),
        .pol_i  (pol_q),
        .evt_o  (pin_evt)
    );

    wake_regs #(.N_PINS(N_PINS)) i_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .op_i    (op),
        .sel_i   (sel),
        .idx_i   (bus_idx_i),
        .wdata_i (bus_wdata_i),
        .evt_i   (pin_evt),
        .pol_o   (pol_q),
        .en_o    (en_q),
        .pend_o  (pend_q)
    );

    always_comb begin
        case (sel)
            SEL_POL:  rd_data_o = pol_q;
            SEL_EN:   rd_data_o = en_q;
            SEL_PEND: rd_data_o = pend_q;
            default:  rd_data_o = '0;
        endcase
        wake_req_o = |(en_q & pend_q);
        halt_ok_o  = halt_req_i & ~wake_req_o;
    end
endmodule

// File: rtl/wake_edge_ctrl_chk.sv
module wake_edge_ctrl_chk #(
    parameter int N_PINS = 8,
    localparam int IDX_W = $clog2(N_PINS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        bus_op_i,
    input logic [1:0]        bus_sel_i,
    input logic [IDX_W-1:0]  bus_idx_i,
    input logic [N_PINS-1:0] bus_wdata_i,
    input logic [N_PINS-1:0] sync_i,
    input logic [N_PINS-1:0] pol_i,
    input logic [N_PINS-1:0] en_i,
    input logic [N_PINS-1:0] pend_i,
    input logic              halt_ok_i
);
    logic [N_PINS-1:0] sw_clr;

    always_comb begin
        sw_clr = '0;
        if (bus_sel_i == 2'd2) begin
            if (bus_op_i == 2'd1) sw_clr = ~bus_wdata_i;
            if (bus_op_i == 2'd3) sw_clr = {{(N_PINS-1){1'b0}}, 1'b1} << bus_idx_i;
        end
    end

    // R2: a set pending bit only drops when software cleared it
    a_r2_pend_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(pend_i) & ~$past(sw_clr) & ~pend_i) == '0));

    // R3: reset leaves polarity and enable at zero
    a_r3_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (pol_i == '0 && en_i == '0));

    // R5: HALT is never granted while an enabled bit is pending
    a_r5_halt_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        halt_ok_i |-> ((en_i & pend_i) == '0));

    // R1: with static pins, polarity and an idle bus nothing new becomes pending
    a_r1_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(sync_i) && $stable(pol_i) && bus_op_i == 2'd0)
        |=> ((pend_i & ~$past(pend_i)) == '0));
endmodule

bind wake_edge_ctrl wake_edge_ctrl_chk #(.N_PINS(N_PINS)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_op_i    (bus_op_i),
    .bus_sel_i   (bus_sel_i),
    .bus_idx_i   (bus_idx_i),
    .bus_wdata_i (bus_wdata_i),
    .sync_i      (pin_sync),
    .pol_i       (pol_q),
    .en_i        (en_q),
    .pend_i      (pend_q),
    .halt_ok_i   (halt_ok_o)
);

// File: tb/test_wake_edge_ctrl.sv
`timescale 1ns/1ps
module test_wake_edge_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pin = 8'h00;
    logic [1:0] op = 2'd0;
    logic [1:0] sel = 2'd3;
    logic [2:0] idx = 3'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rd;
    logic       halt_req = 1'b0;
    logic       wake_req;
    logic       halt_ok;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    wake_edge_ctrl i_wake_edge_ctrl (
        .clk(clk), .rst_n(rst_n), .pin_i(pin), .bus_op_i(op), .bus_sel_i(sel),
        .bus_idx_i(idx), .bus_wdata_i(wdata), .rd_data_o(rd),
        .halt_req_i(halt_req), .wake_req_o(wake_req), .halt_ok_o(halt_ok)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic bus(input logic [1:0] o, input logic [1:0] s, input logic [2:0] i, input logic [7:0] d);
        @(negedge clk);
        op = o; sel = s; idx = i; wdata = d;
        @(negedge clk);
        op = 2'd0; sel = 2'd3;
    endtask

    task automatic rd_reg(input logic [1:0] s, output logic [7:0] v);
        sel = s;
        #0.5;
        v = rd;
        sel = 2'd3;
    endtask

    task automatic wait_neg(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin
        #200000;
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        wait_neg(3);
        rst_n = 1'b1;
        wait_neg(2);

        // R3: reset state
        rd_reg(2'd0, v); check(v == 8'h00, "R3 polarity reset", v, 0);
        rd_reg(2'd1, v); check(v == 8'h00, "R3 enable reset", v, 0);
        check(wake_req == 1'b0, "R4 no request after reset", wake_req, 0);
        bus(2'd1, 2'd2, 3'd0, 8'h00);
        rd_reg(2'd3, v); check(v == 8'h00, "R6 unselected reads zero", v, 0);

        // R6: single-bit set and clear, byte write
        bus(2'd2, 2'd1, 3'd3, 8'h00);
        rd_reg(2'd1, v); check(v == 8'h08, "R6 bit set", v, 8'h08);
        bus(2'd1, 2'd1, 3'd0, 8'hF1);
        bus(2'd3, 2'd1, 3'd4, 8'h00);
        rd_reg(2'd1, v); check(v == 8'hE1, "R6 bit clear after write", v, 8'hE1);
        bus(2'd1, 2'd1, 3'd0, 8'h00);

        // R1 and R2: every pin, both polarities, both directions, enables off
        for (int p = 0; p < 8; p++) begin
            for (int pol = 0; pol < 2; pol++) begin
                bus(2'd1, 2'd0, 3'd0, pol ? (8'h01 << p) : 8'h00);
                wait_neg(3);
                bus(2'd1, 2'd2, 3'd0, 8'h00);
                @(negedge clk); pin[p] = 1'b1;
                wait_neg(4);
                rd_reg(2'd2, v);
                check(v == (pol == 0 ? (8'h01 << p) : 8'h00), "R1 rising transition", v, pol == 0 ? (8'h01 << p) : 0);
                check(wake_req == 1'b0, "R2 latched with enable off, no request", wake_req, 0);
                bus(2'd1, 2'd2, 3'd0, 8'h00);
                @(negedge clk); pin[p] = 1'b0;
                wait_neg(4);
                rd_reg(2'd2, v);
                check(v == (pol == 1 ? (8'h01 << p) : 8'h00), "R1 falling transition", v, pol == 1 ? (8'h01 << p) : 0);
                wait_neg(6);
                rd_reg(2'd2, v);
                check(v == (pol == 1 ? (8'h01 << p) : 8'h00), "R2 pending stays set", v, pol == 1 ? (8'h01 << p) : 0);
            end
        end
        bus(2'd1, 2'd0, 3'd0, 8'h00);
        wait_neg(3);
        bus(2'd1, 2'd2, 3'd0, 8'h00);

        // R9: latency of a pin change
        @(negedge clk); pin[2] = 1'b1;
        @(negedge clk); @(negedge clk);
        rd_reg(2'd2, v); check(v == 8'h00, "R9 not visible after two edges", v, 0);
        @(negedge clk);
        rd_reg(2'd2, v); check(v == 8'h04, "R9 visible after three edges", v, 8'h04);
        @(negedge clk); pin[2] = 1'b0;
        wait_neg(4);
        bus(2'd1, 2'd2, 3'd0, 8'h00);

        // R7: clear vs. hardware event in the same cycle
        bus(2'd2, 2'd2, 3'd5, 8'h00);
        bus(2'd3, 2'd2, 3'd5, 8'h00);
        rd_reg(2'd2, v); check(v == 8'h00, "R6 pending bit clear", v, 0);
        bus(2'd2, 2'd2, 3'd5, 8'h00);
        @(negedge clk); pin[5] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        op = 2'd3; sel = 2'd2; idx = 3'd5;
        @(negedge clk);
        op = 2'd0; sel = 2'd3;
        rd_reg(2'd2, v); check(v == 8'h20, "R7 hardware set wins", v, 8'h20);
        @(negedge clk); pin[5] = 1'b0;
        wait_neg(4);
        bus(2'd1, 2'd2, 3'd0, 8'h00);

        // R8: polarity change with pins low
        bus(2'd1, 2'd0, 3'd0, 8'hFF);
        wait_neg(2);
        rd_reg(2'd2, v); check(v == 8'hFF, "R8 polarity 0->1 fakes event", v, 8'hFF);
        bus(2'd1, 2'd2, 3'd0, 8'h00);
        bus(2'd1, 2'd0, 3'd0, 8'h00);
        wait_neg(3);
        rd_reg(2'd2, v); check(v == 8'h00, "R8 polarity 1->0 no event", v, 0);

        // R4 and R5: request and halt gating over many patterns
        for (int k = 0; k < 48; k++) begin
            logic [7:0] ev, pv;
            ev = 8'(k * 37) ^ 8'h5A;
            pv = 8'(k * 91 + 3);
            if (k % 5 == 0) pv = ~ev;
            bus(2'd1, 2'd1, 3'd0, ev);
            bus(2'd1, 2'd2, 3'd0, pv);
            halt_req = k[0];
            #0.5;
            check(wake_req == |(ev & pv), "R4 request level", wake_req, |(ev & pv));
            check(halt_ok == (k[0] & ~|(ev & pv)), "R5 halt gating", halt_ok, k[0] & ~|(ev & pv));
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule